// File: doc/BRIEF.md
# Programmable Six-Mode Interval Counter Channel

This block is a single timer channel built around a 16-bit down-counter. Software-side logic delivers a start value and a 3-bit operating mode through a one-cycle load strobe. After that, the channel counts qualified clock ticks and shapes its output pin to suit the mode. The modes are an interrupt on terminal count, a gate-retriggerable one-shot, a rate generator, a square-wave generator, and software- and gate-triggered strobes. A gate input pauses counting or retriggers it, depending on the mode.

The output pin also feeds an interrupt request, and a separate enable input masks it. The counter value is visible at all times on a port, so surrounding read-back logic can sample it. A start value of zero means a full period of 65536 ticks. Mode codes 6 and 7 act as aliases of the rate and square-wave modes.

Top module: `tmr_channel`

## Requirements
- R1: After reset the count reads 0 and the output pin is low, and ticks change neither until the first load.
- R2: On the cycle after a load strobe, the count equals the loaded value (square-wave mode with an odd value loads value+1). The pin is low for mode codes 0 and 1 and high for every other code.
- R3: Outside square-wave mode, each accepted tick lowers the count by exactly one, wrapping from 0 to 0xFFFF. A loaded 0 therefore spans 65536 ticks. With no tick, no load and no gate edge, the count holds.
- R4: In mode 0, after a load of N the pin rises on the N-th tick and stays high.
- R5: In mode 1 the pin goes low at a load or at a gate rising edge, and returns high on the N-th tick after that trigger.
- R6: In mode 2 the pin is low for exactly one tick when the count reaches 1. The count then reloads N, giving a period of N ticks.
- R7: In mode 3 the count falls by two per tick, and the pin alternates between halves. For odd N the high half lasts (N+1)/2 ticks and the low half (N-1)/2.
- R8: In modes 4 and 5 the pin pulses low for exactly one tick on the N-th tick after a trigger. After that it stays high while the count keeps wrapping.
- R9: A low gate freezes the count in modes 0, 2, 3 and 4. In modes 2 and 3 it also forces the pin high on the next cycle.
- R10: A gate rising edge reloads the start value in modes 1, 2, 3 and 5, and has no reload effect in modes 0 and 4.
- R11: Mode codes 6 and 7 behave exactly like codes 2 and 3.
- R12: The interrupt line is low whenever the enable input is low. While the enable is high, the line follows the pin, so re-enabling shows the current pin level at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle count tick qualifier |
| gate | input | 1 | Gate level (pause / retrigger) |
| loadStb | input | 1 | Load start value and mode this cycle |
| loadCount | input | 16 | Start value, 0 meaning 65536 |
| modeSel | input | 3 | Operating mode code |
| irqEn | input | 1 | Interrupt enable mask |
| count | output | 16 | Current counter value |
| outPin | output | 1 | Mode-shaped timer output |
| irq | output | 1 | Masked interrupt request |

## Verification
The bound checker holds several rules every cycle: idle behaviour before the first load, the value and pin level after a load, the single-step decrement, the by-two step in square-wave mode, freezing and forced-high under a low gate, and interrupt masking. Whole waveform timing needs the bench's scenarios, which compare against a tick-level model on every clock. That covers the N-tick terminal delay, the rate-generator period, the uneven halves of an odd square wave, one-shot retriggering, single strobe pulses, and the mode 6/7 aliases.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    MD_TERM       = 3'd0,
    MD_ONESHOT    = 3'd1,
    MD_RATE       = 3'd2,
    MD_SQUARE     = 3'd3,
    MD_SOFTSTROBE = 3'd4,
    MD_GATESTROBE = 3'd5
  } mode_e;

  typedef enum logic [1:0] {
    SEL_INIT    = 2'd0,
    SEL_EVEN_UP = 2'd1,
    SEL_EVEN_DN = 2'd2
  } sel_e;

  typedef struct packed {
    logic ldInit;
    logic ldCnt;
    sel_e sel;
    logic dec1;
    logic dec2;
  } dpCtrl_t;
endpackage

// File: rtl/tmr_dp.sv
module tmr_dp
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          dpCtl,
  input  logic [CNT_W-1:0] loadCount,
  output logic [CNT_W-1:0] count,
  output logic             cntIsOne,
  output logic             cntIsTwo
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] initQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntD;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] reloadVal;

  // the start value is taken straight from the port in the load cycle
  assign base = dpCtl.ldInit ? loadCount : initQ;

  always_comb begin
    case (dpCtl.sel)
      SEL_EVEN_UP: reloadVal = base + CNT_W'(base[0]);
      SEL_EVEN_DN: reloadVal = base - CNT_W'(base[0]);
      default:     reloadVal = base;
    endcase
  end

  always_comb begin
    cntD = cntQ;
    if (dpCtl.ldCnt)     cntD = reloadVal;
    else if (dpCtl.dec2) cntD = cntQ - TWO;
    else if (dpCtl.dec1) cntD = cntQ - ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initQ <= '0;
      cntQ  <= '0;
    end else begin
      if (dpCtl.ldInit) initQ <= loadCount;
      cntQ <= cntD;
    end
  end

  assign count    = cntQ;
  assign cntIsOne = (cntQ == ONE);
  assign cntIsTwo = (cntQ == TWO);
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       gate,
  input  logic       loadStb,
  input  logic [2:0] modeSel,
  input  logic       cntIsOne,
  input  logic       cntIsTwo,
  output dpCtrl_t    dpCtl,
  output logic       outPin
);
  mode_e modeQ, modeD, modeIn;
  logic  outQ, outD;
  logic  armedQ, armedD;
  logic  runQ, runD;
  logic  gatePrevQ;
  logic  gateRise, retrig, gateHalts, gateForcesHigh, tickHere;

  function automatic sel_e startSel(input mode_e m);
    return (m == MD_SQUARE) ? SEL_EVEN_UP : SEL_INIT;
  endfunction

  // codes 6 and 7 fold onto the periodic modes
  always_comb begin
    if (modeSel[2:1] == 2'b11) modeIn = mode_e'({1'b0, modeSel[1:0]});
    else                       modeIn = mode_e'(modeSel);
  end

  assign gateRise       = gate & ~gatePrevQ;
  assign retrig         = modeQ inside {MD_ONESHOT, MD_RATE, MD_SQUARE, MD_GATESTROBE};
  assign gateForcesHigh = modeQ inside {MD_RATE, MD_SQUARE};
  assign gateHalts      = modeQ inside {MD_TERM, MD_RATE, MD_SQUARE, MD_SOFTSTROBE};
  assign tickHere       = runQ & tickEn & (gate | ~gateHalts);

  always_comb begin
    dpCtl  = '0;
    modeD  = modeQ;
    outD   = outQ;
    armedD = armedQ;
    runD   = runQ;
    if (loadStb) begin
      modeD        = modeIn;
      runD         = 1'b1;
      armedD       = 1'b1;
      dpCtl.ldInit = 1'b1;
      dpCtl.ldCnt  = 1'b1;
      dpCtl.sel    = startSel(modeIn);
      outD         = !(modeIn inside {MD_TERM, MD_ONESHOT});
    end else if (runQ && gateRise && retrig) begin
      armedD      = 1'b1;
      dpCtl.ldCnt = 1'b1;
      dpCtl.sel   = startSel(modeQ);
      outD        = (modeQ != MD_ONESHOT);
    end else if (tickHere) begin
      case (modeQ)
        MD_RATE: begin
          if (cntIsOne) begin
            dpCtl.ldCnt = 1'b1;
            dpCtl.sel   = SEL_INIT;
            outD        = 1'b1;
          end else begin
            dpCtl.dec1 = 1'b1;
            outD       = ~cntIsTwo;
          end
        end
        MD_SQUARE: begin
          if (cntIsTwo) begin
            dpCtl.ldCnt = 1'b1;
            dpCtl.sel   = outQ ? SEL_EVEN_DN : SEL_EVEN_UP;
            outD        = ~outQ;
          end else begin
            dpCtl.dec2 = 1'b1;
          end
        end
        MD_SOFTSTROBE, MD_GATESTROBE: begin
          dpCtl.dec1 = 1'b1;
          if (cntIsOne && armedQ) begin
            outD   = 1'b0;
            armedD = 1'b0;
          end else begin
            outD = 1'b1;
          end
        end
        default: begin
          dpCtl.dec1 = 1'b1;
          if (cntIsOne) outD = 1'b1;
        end
      endcase
    end else if (!gate && gateForcesHigh) begin
      outD = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ     <= MD_TERM;
      outQ      <= 1'b0;
      armedQ    <= 1'b0;
      runQ      <= 1'b0;
      gatePrevQ <= 1'b0;
    end else begin
      modeQ     <= modeD;
      outQ      <= outD;
      armedQ    <= armedD;
      runQ      <= runD;
      gatePrevQ <= gate;
    end
  end

  assign outPin = outQ;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             gate,
  input  logic             loadStb,
  input  logic [CNT_W-1:0] loadCount,
  input  logic [2:0]       modeSel,
  input  logic             irqEn,
  output logic [CNT_W-1:0] count,
  output logic             outPin,
  output logic             irq
);
  dpCtrl_t dpCtl;
  logic    cntIsOne;
  logic    cntIsTwo;

  tmr_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .gate     (gate),
    .loadStb  (loadStb),
    .modeSel  (modeSel),
    .cntIsOne (cntIsOne),
    .cntIsTwo (cntIsTwo),
    .dpCtl    (dpCtl),
    .outPin   (outPin)
  );

  tmr_dp #(.CNT_W(CNT_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .dpCtl     (dpCtl),
    .loadCount (loadCount),
    .count     (count),
    .cntIsOne  (cntIsOne),
    .cntIsTwo  (cntIsTwo)
  );

  assign irq = outPin & irqEn;
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             gate,
  input logic             loadStb,
  input logic [CNT_W-1:0] loadCount,
  input logic [2:0]       modeSel,
  input logic             irqEn,
  input logic [CNT_W-1:0] count,
  input logic             outPin,
  input logic             irq
);
  logic       loadedQ;
  logic [2:0] modeQ;
  logic       gatePrevQ;
  logic       gateUp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadedQ   <= 1'b0;
      modeQ     <= 3'd0;
      gatePrevQ <= 1'b0;
    end else begin
      gatePrevQ <= gate;
      if (loadStb) begin
        loadedQ <= 1'b1;
        modeQ   <= (modeSel[2:1] == 2'b11) ? {1'b0, modeSel[1:0]} : modeSel;
      end
    end
  end

  assign gateUp = gate && !gatePrevQ;

  p_idle_until_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    !loadedQ |-> (count == '0 && !outPin));

  p_load_value_r2: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && modeSel != 3'd3 && modeSel != 3'd7) |=> count == $past(loadCount));

  p_load_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && modeSel[2:1] == 2'b00) |=> !outPin);

  p_load_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && modeSel[2:1] != 2'b00) |=> outPin);

  p_count_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!loadStb && !tickEn && gate == gatePrevQ) |=> $stable(count));

  p_step_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    (loadedQ && !loadStb && tickEn && !gateUp && modeQ inside {3'd0, 3'd1, 3'd4, 3'd5}
     && (gate || modeQ == 3'd1 || modeQ == 3'd5))
    |=> count == ($past(count) - 1'b1));

  p_step_two_r7: assert property (@(posedge clk) disable iff (!rstN)
    (loadedQ && !loadStb && tickEn && gate && gatePrevQ && modeQ == 3'd3 && count != CNT_W'(2))
    |=> count == ($past(count) - 2'd2));

  p_gate_freeze_r9: assert property (@(posedge clk) disable iff (!rstN)
    (loadedQ && !loadStb && !gate && modeQ inside {3'd0, 3'd2, 3'd3, 3'd4}) |=> $stable(count));

  p_gate_force_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    (loadedQ && !loadStb && !gate && modeQ inside {3'd2, 3'd3}) |=> outPin);

  p_irq_masked_r12: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !irq);

  p_irq_restore_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqEn) |-> (irq == outPin));
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .tickEn    (tickEn),
  .gate      (gate),
  .loadStb   (loadStb),
  .loadCount (loadCount),
  .modeSel   (modeSel),
  .irqEn     (irqEn),
  .count     (count),
  .outPin    (outPin),
  .irq       (irq)
);

// File: tb/tmr_channel_tb_top.sv
module tmr_channel_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        gate = 1'b1;
  logic        loadStb = 1'b0;
  logic [15:0] loadCount = '0;
  logic [2:0]  modeSel = '0;
  logic        irqEn = 1'b1;
  logic [15:0] count;
  logic        outPin;
  logic        irq;

  int    checks = 0;
  int    fails = 0;
  string curReq = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_channel dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .gate(gate), .loadStb(loadStb),
    .loadCount(loadCount), .modeSel(modeSel), .irqEn(irqEn),
    .count(count), .outPin(outPin), .irq(irq)
  );

  // tick-level reference model
  int mMode, mInit, mCnt, mOut, mArmed, mRun, mGp;

  function automatic int evenUp(input int n);
    return (n + (n % 2)) % 65536;
  endfunction
  function automatic int evenDn(input int n);
    return n - (n % 2);
  endfunction

  always @(posedge clk or negedge rstN) begin
    bit rise;
    if (!rstN) begin
      mMode = 0; mInit = 0; mCnt = 0; mOut = 0; mArmed = 0; mRun = 0; mGp = 0;
    end else begin
      rise = gate && (mGp == 0);
      mGp  = gate;
      if (loadStb) begin
        mMode  = (modeSel >= 6) ? int'(modeSel) - 4 : int'(modeSel);
        mInit  = loadCount;
        mRun   = 1;
        mArmed = 1;
        mCnt   = (mMode == 3) ? evenUp(mInit) : mInit;
        mOut   = (mMode <= 1) ? 0 : 1;
      end else if (mRun == 1 && rise && mMode inside {1, 2, 3, 5}) begin
        mCnt   = (mMode == 3) ? evenUp(mInit) : mInit;
        mOut   = (mMode == 1) ? 0 : 1;
        mArmed = 1;
      end else if (mRun == 1 && tickEn && (gate || mMode == 1 || mMode == 5)) begin
        if (mMode == 2) begin
          if (mCnt == 1) begin mCnt = mInit; mOut = 1; end
          else begin mCnt = (mCnt + 65535) % 65536; mOut = (mCnt == 1) ? 0 : 1; end
        end else if (mMode == 3) begin
          if (mCnt == 2) begin
            mOut = 1 - mOut;
            mCnt = (mOut == 1) ? evenUp(mInit) : evenDn(mInit);
          end else mCnt = (mCnt + 65534) % 65536;
        end else if (mMode == 4 || mMode == 5) begin
          if (mCnt == 1 && mArmed == 1) begin mOut = 0; mArmed = 0; end
          else mOut = 1;
          mCnt = (mCnt + 65535) % 65536;
        end else begin
          if (mCnt == 1) mOut = 1;
          mCnt = (mCnt + 65535) % 65536;
        end
      end else if (!gate && (mMode == 2 || mMode == 3)) begin
        mOut = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (count !== 16'(mCnt) || outPin !== mOut[0] || irq !== (mOut[0] && irqEn)) begin
        fails++;
        $display("FAIL %s model: actual cnt=%0d out=%0d irq=%0d expected cnt=%0d out=%0d irq=%0d",
                 curReq, count, outPin, irq, mCnt, mOut, mOut[0] && irqEn);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic loadCh(input logic [2:0] m, input logic [15:0] n);
    @(negedge clk);
    modeSel = m; loadCount = n; loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  task automatic waitOut(input logic lvl, output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (outPin !== lvl && k < 200);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int k, lows, c;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(count == 0 && !outPin, "R1 reset state", count, 0);
    tickEn = 1'b1;
    repeat (4) @(negedge clk);
    chk(count == 0, "R1 idle before load", count, 0);

    curReq = "R4";
    loadCh(3'd0, 16'd5);
    chk(count == 5 && !outPin, "R2 load mode0", count, 5);
    waitOut(1'b1, k);
    chk(k == 5, "R4 terminal after N ticks", k, 5);
    @(negedge clk);
    chk(count == 16'hFFFF && outPin, "R3 wrap keeps high", count, 65535);

    curReq = "R3";
    loadCh(3'd0, 16'd0);
    @(negedge clk);
    chk(count == 16'hFFFF, "R3 zero load wraps", count, 65535);

    curReq = "R9";
    gate = 1'b0;
    loadCh(3'd0, 16'd10);
    repeat (5) @(negedge clk);
    chk(count == 10, "R9 gate low freezes mode0", count, 10);
    gate = 1'b1;
    @(negedge clk);
    chk(count == 9, "R10 no restart in mode0", count, 9);

    curReq = "R6";
    loadCh(3'd2, 16'd4);
    chk(outPin, "R2 load mode2 high", outPin, 1);
    waitOut(1'b0, k);
    chk(k == 3, "R6 first low pulse", k, 3);
    waitOut(1'b1, k);
    chk(k == 1, "R6 low lasts one tick", k, 1);
    waitOut(1'b0, k);
    chk(k == 3, "R6 period N", k + 1, 4);

    curReq = "R11";
    loadCh(3'd6, 16'd3);
    waitOut(1'b0, k);
    chk(k == 2, "R11 code 6 as rate", k, 2);

    curReq = "R7";
    loadCh(3'd3, 16'd5);
    chk(count == 6, "R7 odd load rounds up", count, 6);
    waitOut(1'b0, k);
    chk(k == 3, "R7 high half", k, 3);
    waitOut(1'b1, k);
    chk(k == 2, "R7 low half", k, 2);
    waitOut(1'b0, k);
    curReq = "R9";
    gate = 1'b0;
    @(negedge clk);
    chk(outPin, "R9 gate low forces high", outPin, 1);
    c = count;
    repeat (3) @(negedge clk);
    chk(count == 16'(c), "R9 square frozen", count, c);
    gate = 1'b1;
    @(negedge clk);
    chk(count == 6 && outPin, "R10 square restart", count, 6);

    curReq = "R11";
    loadCh(3'd7, 16'd4);
    waitOut(1'b0, k);
    chk(k == 2, "R11 code 7 as square", k, 2);

    curReq = "R8";
    loadCh(3'd4, 16'd3);
    lows = 0; k = 0;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (!outPin) begin lows++; k = i; end
    end
    chk(lows == 1, "R8 single pulse", lows, 1);
    chk(k == 3, "R8 pulse on N-th tick", k, 3);

    curReq = "R10";
    gate = 1'b0;
    loadCh(3'd5, 16'd3);
    repeat (10) @(negedge clk);
    gate = 1'b1;
    @(negedge clk);
    chk(count == 3 && outPin, "R10 gate strobe retrigger", count, 3);
    waitOut(1'b0, k);
    chk(k == 3, "R8 gate strobe pulse", k, 3);

    curReq = "R5";
    gate = 1'b0;
    loadCh(3'd1, 16'd4);
    chk(!outPin, "R5 low after load", outPin, 0);
    waitOut(1'b1, k);
    chk(k == 4, "R5 high after N", k, 4);
    gate = 1'b1;
    @(negedge clk);
    chk(!outPin && count == 4, "R5 retrigger low", count, 4);
    waitOut(1'b1, k);
    chk(k == 4, "R5 retrigger length", k, 4);

    curReq = "R12";
    irqEn = 1'b0;
    @(negedge clk);
    chk(!irq, "R12 masked", irq, 0);
    irqEn = 1'b1;
    #1;
    chk(irq == outPin && irq, "R12 restore level", irq, 1);

    curReq = "R3";
    loadCh(3'd0, 16'd8);
    for (int i = 0; i < 8; i++) begin
      tickEn = i[0];
      @(negedge clk);
    end
    tickEn = 1'b1;
    chk(count == 4, "R3 only qualified ticks count", count, 4);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule